// File: doc/BRIEF.md
# 16x Oversampling Baud Tick Generator

This block turns the system clock into a stream of one-cycle sample ticks for a serial transmitter and receiver that oversample each bit sixteen times. The tick period, in clocks, is a 16-bit divisor made of two byte-wide latches. The resulting bit rate is the clock frequency divided by sixteen times the divisor. Software reaches the two latches through a small byte port. The port only works while an access-enable input is high, so that elsewhere in the chip the same addresses can serve other registers.

A divisor of zero stops the tick completely. Writing either byte reloads the down-counter at once, so a new rate applies from the next period. Writing the low byte also starts a settle window of eight clocks. A ready output stays low during that window, and whenever the divisor is zero, so the serial logic does not start on an unstable rate.

Top module: `udiv_tick_gen`

## Requirements
- R1: After reset both divisor bytes read as 0x00, the tick output is low and the ready output is low.
- R2: While the access input is 1, a write with sel=0 loads the low byte and a write with sel=1 loads the high byte. The selected byte reads back on rdata in the same cycle it is addressed.
- R3: While the access input is 0, writes change no divisor byte and rdata reads 0x00.
- R4: The divisor is {high byte, low byte}. After a divisor write at clock edge E0, the first tick is high in the cycle after edge E0+D, where D is the new divisor. Ticks then repeat every D clocks.
- R5: For a divisor of 2 or more, each tick lasts exactly one clock. A divisor of 1 holds the tick high on every cycle.
- R6: With a divisor of zero, no tick is produced and ready stays low.
- R7: After a low-byte write, ready is low for the next 8 cycles and rises in the 9th, provided the divisor is nonzero.
- R8: A high-byte write reloads the counter, so the next tick comes D clocks later, but it does not restart the settle window.
- R9: A divisor with only the high byte set (0x0100) gives a tick period of 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_access | input | 1 | Enables reads and writes of the divisor bytes |
| wr_en | input | 1 | Write strobe for the addressed byte |
| sel | input | SEL_W (1) | Byte select: 0 is the low byte, 1 is the high byte |
| wdata | input | BYTE_W (8) | Write data |
| rdata | output | BYTE_W (8) | Addressed byte, or zero while access is off |
| tick | output | 1 | One-cycle 16x sample tick |
| ready | output | 1 | High once the divisor is nonzero and has settled |

## Verification
The bench measures the latency from the write edge to the first tick, and the gap between ticks. A counter that reloads one cycle late, or that fires at zero instead of at one, is off by one clock. A divisor of one is checked separately, because a design that always deasserts the tick after it fires would halve the rate. A zero divisor must stay silent: an unguarded down-counter would wrap and tick every 65536 clocks. The settle window is measured to the exact cycle. A high-byte write must move the tick phase and leave ready high, which catches a design that ties the settle timer to every write.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

  // Action taken by the tick down-counter on each clock.
  typedef enum logic [1:0] {
    ACT_RELOAD_WR = 2'd0,  // a divisor byte was written: load the new divisor
    ACT_HALT      = 2'd1,  // divisor is zero: park the counter
    ACT_FIRE      = 2'd2,  // counter reached one: emit tick and reload
    ACT_COUNT     = 2'd3   // plain decrement
  } cnt_act_e;

  // Width needed to hold the values 0..n.
  function automatic int settle_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/udiv_latch.sv
module udiv_latch #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int SEL_W     = 1,
  parameter int DIV_W     = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic [DIV_W-1:0]  div_next,
  output logic              wr_any,
  output logic              wr_low
);

  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_q;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_d;
  logic [NUM_BYTES-1:0]             hit;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    assign hit[g]     = access && wr_en && (sel == SEL_W'(g));
    assign bytes_d[g] = hit[g] ? wdata : bytes_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n)      bytes_q[g] <= '0;
      else if (hit[g]) bytes_q[g] <= wdata;
    end
  end

  assign divisor  = bytes_q;
  assign div_next = bytes_d;
  assign wr_any   = |hit;
  assign wr_low   = hit[0];
  assign rdata    = access ? bytes_q[sel] : '0;

  // A write attempted while access is off leaves the divisor alone.
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && wr_en) |=> $stable(divisor)); // R3

endmodule

// File: rtl/udiv_counter.sv
module udiv_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [DIV_W-1:0] div_next,
  input  logic             wr_any,
  output logic             tick
);
  import udiv_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  cnt_act_e         act;

  function automatic cnt_act_e pick_action(input logic wr, input logic zero,
                                           input logic at_one);
    if (wr)          return ACT_RELOAD_WR;
    else if (zero)   return ACT_HALT;
    else if (at_one) return ACT_FIRE;
    else             return ACT_COUNT;
  endfunction

  assign act = pick_action(wr_any, divisor == '0, cnt_q <= DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      case (act)
        ACT_RELOAD_WR: begin cnt_q <= div_next;         tick <= 1'b0; end
        ACT_HALT:      begin cnt_q <= '0;               tick <= 1'b0; end
        ACT_FIRE:      begin cnt_q <= divisor;          tick <= 1'b1; end
        default:       begin cnt_q <= cnt_q - DIV_W'(1); tick <= 1'b0; end
      endcase
    end
  end

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> !tick); // R6
  AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1)) |=> !tick); // R5
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !tick); // R4

endmodule

// File: rtl/udiv_settle.sv
module udiv_settle #(
  parameter int SETTLE_CYCLES = 8,
  parameter int DIV_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_low,
  input  logic [DIV_W-1:0] divisor,
  output logic             ready
);
  localparam int CW = udiv_pkg::settle_width(SETTLE_CYCLES);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            wait_q <= '0;
    else if (wr_low)       wait_q <= CW'(SETTLE_CYCLES);
    else if (wait_q != '0) wait_q <= wait_q - CW'(1);
  end

  assign ready = (wait_q == '0) && (divisor != '0);

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low |=> !ready); // R7

endmodule

// File: rtl/udiv_tick_gen.sv
module udiv_tick_gen #(
  parameter int BYTE_W        = 8,
  parameter int NUM_BYTES     = 2,
  parameter int SETTLE_CYCLES = 8,
  localparam int SEL_W        = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int DIV_W        = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_access,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              tick,
  output logic              ready
);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] div_next;
  logic             wr_any;
  logic             wr_low;

  udiv_latch #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SEL_W(SEL_W), .DIV_W(DIV_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .access(div_access), .wr_en(wr_en),
    .sel(sel), .wdata(wdata), .rdata(rdata), .divisor(divisor),
    .div_next(div_next), .wr_any(wr_any), .wr_low(wr_low)
  );

  udiv_counter #(.DIV_W(DIV_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .div_next(div_next),
    .wr_any(wr_any), .tick(tick)
  );

  udiv_settle #(.SETTLE_CYCLES(SETTLE_CYCLES), .DIV_W(DIV_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .wr_low(wr_low), .divisor(divisor),
    .ready(ready)
  );

  AST_HIGH_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_any && !wr_low && div_next != '0) |=> ready); // R8

endmodule

// File: tb/udiv_tick_gen_bench.sv
module udiv_tick_gen_bench;
  localparam int PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_access = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick;
  logic       ready;

  int n_checks = 0;
  int n_fail   = 0;

  always #(PERIOD/2) clk = ~clk;

  udiv_tick_gen u_udiv_tick_gen (
    .clk(clk), .rst_n(rst_n), .div_access(div_access), .wr_en(wr_en),
    .sel(sel), .wdata(wdata), .rdata(rdata), .tick(tick), .ready(ready)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Write ends at the negedge following the capturing edge E0.
  task automatic wr_byte(input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cycles_to_tick(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick && k < 2000);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick", tick, 0);
    check("R1 ready", ready, 0);
    div_access = 1'b1; sel = 1'b0; #1;
    check("R1 low byte", rdata, 0);
    sel = 1'b1; #1;
    check("R1 high byte", rdata, 0);
  endtask

  task automatic t_rw_and_lock;
    div_access = 1'b1;
    wr_byte(1'b0, 8'h2A);
    wr_byte(1'b1, 8'h03);
    sel = 1'b0; #1; check("R2 low readback", rdata, 8'h2A);
    sel = 1'b1; #1; check("R2 high readback", rdata, 8'h03);
    div_access = 1'b0;
    sel = 1'b0; #1; check("R3 rdata masked", rdata, 0);
    wr_byte(1'b0, 8'h55);
    wr_byte(1'b1, 8'h77);
    div_access = 1'b1;
    sel = 1'b0; #1; check("R3 low unchanged", rdata, 8'h2A);
    sel = 1'b1; #1; check("R3 high unchanged", rdata, 8'h03);
  endtask

  task automatic t_period;
    int k;
    div_access = 1'b1;
    wr_byte(1'b1, 8'h00);
    wr_byte(1'b0, 8'd5);
    cycles_to_tick(k);
    check("R4 first tick latency", k, 5);
    @(negedge clk);
    check("R5 tick one wide", tick, 0);
    cycles_to_tick(k);
    check("R4 tick spacing", k + 1, 5);
  endtask

  task automatic t_div_one;
    int k;
    int highs = 0;
    wr_byte(1'b0, 8'd1);
    cycles_to_tick(k);
    check("R4 divisor one latency", k, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (tick) highs++;
    end
    check("R5 divisor one steady tick", highs, 4);
  endtask

  task automatic t_settle;
    int k = 0;
    wr_byte(1'b0, 8'd12);
    check("R7 ready low after write", ready, 0);
    while (!ready && k < 100) begin @(negedge clk); k++; end
    check("R7 settle length", k, 8);
  endtask

  task automatic t_high_reload;
    int k;
    wr_byte(1'b1, 8'h00);
    wr_byte(1'b0, 8'd10);
    repeat (20) @(negedge clk);
    check("R7 ready after settle", ready, 1);
    repeat (3) @(negedge clk);
    wr_byte(1'b1, 8'h00);
    check("R8 ready kept on high write", ready, 1);
    cycles_to_tick(k);
    check("R8 high write reloads", k, 10);
  endtask

  task automatic t_wide;
    int k;
    wr_byte(1'b0, 8'h00);
    wr_byte(1'b1, 8'h01);
    cycles_to_tick(k);
    check("R9 high byte period", k, 256);
    cycles_to_tick(k);
    check("R9 high byte spacing", k, 256);
  endtask

  task automatic t_zero;
    int bad = 0;
    wr_byte(1'b0, 8'h00);
    wr_byte(1'b1, 8'h00);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick || ready) bad++;
    end
    check("R6 zero divisor silent", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rw_and_lock();
    t_period();
    t_div_one();
    t_settle();
    t_high_reload();
    t_wide();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule